// File: doc/BRIEF.md
# Memory Bus Decoder with Boot Overlay

This block sits between an 8-bit CPU core and the on-chip storage of a small handheld-style system. It takes a 16-bit address with separate read and write enables and steers each access to the right array. The arrays are video RAM, work RAM (also visible through a mirror window), sprite attribute RAM, a 76-byte I/O register file, high RAM and an interrupt-enable register. Cartridge ROM is not held on chip. Reads of that space go out through a combinational ROM port.

At power-up a small boot program can be laid over the bottom of the cartridge space. Once software writes anything to the overlay-off address, the overlay is gone until the next reset. Unused holes in the map return fixed values and drop writes. A debug path emits the serial data byte as a one-cycle strobe whenever software writes the start code to the serial control register. Read data is registered: a read asked for in cycle N is visible on `rd_data` after the edge that ends cycle N.

The default parameters shrink video and work RAM to 1 KiB each. The in-region index is the low address bits, so a smaller array aliases within its window. Setting both widths to 13 gives the full 8 KiB arrays.

Top module: `membus_decoder`

## Requirements
- R1: For 0x0000–0x7FFF when the overlay does not apply, `rom_addr` equals `req_addr[14:0]` and a read returns `rom_data`. Writes to this region change nothing.
- R2: While the overlay is active and the address is below BOOT_LEN, a read of offset k returns the boot byte `((k[7:0] XOR 0x5A) + k[15:8]) mod 256` instead of ROM data.
- R3: The overlay enable takes the value of `boot_en_i` during reset. Any write to 0xFF50 clears it, and it stays cleared until the next reset.
- R4: Video RAM (0x8000–0x9FFF) and work RAM (0xC000–0xDFFF) can be written and read back. The index into each array is the low VRAM_AW or WRAM_AW address bits. Read data appears one clock after the read request.
- R5: 0xE000–0xFDFF reaches the same work RAM cell as the address 0x2000 lower, for both reads and writes.
- R6: 0xFE00–0xFE9F is a 160-byte sprite RAM. 0xFEA0–0xFEFF reads 0x00 and ignores writes.
- R7: 0xA000–0xBFFF reads 0xFF and ignores writes. 0xFF4C–0xFF7F reads 0xFF and stores nothing.
- R8: Every byte of the I/O file at 0xFF00–0xFF4B resets to 0xFF and can be written and read back. A read of 0xFF00 always returns 0xFF.
- R9: 0xFF80–0xFFFE is a 127-byte high RAM. 0xFFFF is an interrupt-enable byte that resets to 0x00.
- R10: A write of 0x81 to 0xFF02 raises `dbg_valid` for exactly the next cycle, with `dbg_byte` equal to the byte held at 0xFF01. The 0x81 is still stored at 0xFF02. No other write raises `dbg_valid`.
- R11: `rd_data` holds its value in cycles with no read. A read and a write to the same cell in one cycle return the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_en_i | input | 1 | Overlay enable value loaded during reset |
| req_addr | input | 16 | Bus address |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rom_addr | output | 15 | Cartridge ROM address |
| rom_data | input | 8 | Cartridge ROM data, combinational |
| dbg_valid | output | 1 | One-cycle serial debug strobe |
| dbg_byte | output | 8 | Serial byte presented with the strobe |

## Verification
The overlay boundary at BOOT_LEN−1 and BOOT_LEN is probed. A wrong length compare would show boot bytes in place of ROM bytes, or the reverse. Clearing the overlay, writing 0xFF50 a second time, and a reset with the enable input low are all checked. A latch that could be set again, or one that ignored the input, would put boot bytes back on the bus.

The mirror is written through one window and read through the other. The holes and 0xFF00 are read after writes, where a decoder leaking into an array would return stored data. The strobe is checked on the cycle after the start write and on the cycle after that, so a level instead of a pulse is caught. A control write with 0x80 must not raise the strobe, which catches a decode that only looks at the address. Constrained random traffic over the whole map, checked against a bench model, covers the remaining region edges.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [3:0] {
    RG_ROM, RG_VRAM, RG_XRAM, RG_WRAM, RG_OAM, RG_HOLE,
    RG_IO, RG_BOOTOFF, RG_UNUSED, RG_HRAM, RG_IE
  } region_e;

  localparam int OAM_BYTES  = 160;
  localparam int IO_BYTES   = 76;
  localparam int HRAM_BYTES = 127;

  localparam logic [15:0] A_SER_DATA = 16'hFF01;
  localparam logic [15:0] A_SER_CTRL = 16'hFF02;
  localparam logic [7:0]  SER_START  = 8'h81;

  // Map an address to its region; the order of the compares matters.
  function automatic region_e decode_region(input logic [15:0] a);
    region_e r;
    if (a < 16'h8000)       r = RG_ROM;
    else if (a < 16'hA000)  r = RG_VRAM;
    else if (a < 16'hC000)  r = RG_XRAM;
    else if (a < 16'hFE00)  r = RG_WRAM;   // work RAM and its mirror
    else if (a < 16'hFEA0)  r = RG_OAM;
    else if (a < 16'hFF00)  r = RG_HOLE;
    else if (a < 16'hFF4C)  r = RG_IO;
    else if (a == 16'hFF50) r = RG_BOOTOFF;
    else if (a < 16'hFF80)  r = RG_UNUSED;
    else if (a < 16'hFFFF)  r = RG_HRAM;
    else                    r = RG_IE;
    return r;
  endfunction

  // Boot program image, computed rather than stored.
  function automatic logic [7:0] boot_image(input logic [15:0] k);
    return (k[7:0] ^ 8'h5A) + k[15:8];
  endfunction

endpackage

// File: rtl/mb_byte_ram.sv
module mb_byte_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Asynchronous read; the top registers the result.
  assign rdata = mem[addr];
endmodule

// File: rtl/mb_io_file.sv
module mb_io_file #(
  parameter int NREG = 76,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [7:0]    ser_byte
);
  logic [7:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'hFF;
    end else if (we) begin
      regs[addr] <= wdata;
    end
  end

  assign rdata    = regs[addr];
  assign ser_byte = regs[1];   // serial data register sits at offset 1
endmodule

// File: rtl/mb_boot_overlay.sv
module mb_boot_overlay
  import membus_pkg::*;
#(
  parameter int BOOT_LEN = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_en_i,
  input  logic        clear_i,
  input  logic [15:0] addr,
  output logic        active_o,
  output logic        hit_o,
  output logic [7:0]  byte_o
);
  logic active_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       active_q <= boot_en_i;
    else if (clear_i) active_q <= 1'b0;   // one-way: nothing sets it again
  end

  assign active_o = active_q;
  assign hit_o    = active_q && (32'(addr) < BOOT_LEN);
  assign byte_o   = boot_image(addr);
endmodule

// File: rtl/membus_decoder.sv
module membus_decoder
  import membus_pkg::*;
#(
  parameter int VRAM_AW  = 10,
  parameter int WRAM_AW  = 10,
  parameter int BOOT_LEN = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_en_i,
  input  logic [15:0] req_addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic [14:0] rom_addr,
  input  logic [7:0]  rom_data,
  output logic        dbg_valid,
  output logic [7:0]  dbg_byte
);
  localparam int VRAM_DEPTH = 1 << VRAM_AW;
  localparam int WRAM_DEPTH = 1 << WRAM_AW;

  region_e rgn;
  assign rgn = decode_region(req_addr);

  // Named events for the checker
  logic boot_active, boot_hit, boot_clear, dbg_fire;
  logic [7:0] boot_byte;

  assign boot_clear = wr_en && (rgn == RG_BOOTOFF);
  assign dbg_fire   = wr_en && (req_addr == A_SER_CTRL) && (wr_data == SER_START);

  mb_boot_overlay #(.BOOT_LEN(BOOT_LEN)) u_boot (
    .clk(clk), .rst_n(rst_n), .boot_en_i(boot_en_i), .clear_i(boot_clear),
    .addr(req_addr), .active_o(boot_active), .hit_o(boot_hit), .byte_o(boot_byte)
  );

  // Every window base is aligned to its size (0xE000 and 0xC000 agree
  // in the low 13 bits), so the low address bits index the arrays,
  // and the mirror needs no subtraction.
  logic [7:0] vram_rd, wram_rd, oam_rd, hram_rd, io_rd, ser_byte;

  mb_byte_ram #(.DEPTH(VRAM_DEPTH)) u_vram (
    .clk(clk), .we(wr_en && rgn == RG_VRAM), .addr(req_addr[VRAM_AW-1:0]),
    .wdata(wr_data), .rdata(vram_rd)
  );

  mb_byte_ram #(.DEPTH(WRAM_DEPTH)) u_wram (
    .clk(clk), .we(wr_en && rgn == RG_WRAM), .addr(req_addr[WRAM_AW-1:0]),
    .wdata(wr_data), .rdata(wram_rd)
  );

  mb_byte_ram #(.DEPTH(OAM_BYTES)) u_oam (
    .clk(clk), .we(wr_en && rgn == RG_OAM), .addr(req_addr[7:0]),
    .wdata(wr_data), .rdata(oam_rd)
  );

  mb_byte_ram #(.DEPTH(HRAM_BYTES)) u_hram (
    .clk(clk), .we(wr_en && rgn == RG_HRAM), .addr(req_addr[6:0]),
    .wdata(wr_data), .rdata(hram_rd)
  );

  mb_io_file #(.NREG(IO_BYTES)) u_io (
    .clk(clk), .rst_n(rst_n), .we(wr_en && rgn == RG_IO), .addr(req_addr[6:0]),
    .wdata(wr_data), .rdata(io_rd), .ser_byte(ser_byte)
  );

  logic [7:0] ie_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                     ie_q <= 8'h00;
    else if (wr_en && rgn == RG_IE) ie_q <= wr_data;
  end

  assign rom_addr = req_addr[14:0];

  logic [7:0] rd_next;
  always_comb begin
    unique case (rgn)
      RG_ROM:  rd_next = boot_hit ? boot_byte : rom_data;
      RG_VRAM: rd_next = vram_rd;
      RG_WRAM: rd_next = wram_rd;
      RG_OAM:  rd_next = oam_rd;
      RG_HOLE: rd_next = 8'h00;
      RG_IO:   rd_next = (req_addr[6:0] == 7'd0) ? 8'hFF : io_rd;
      RG_HRAM: rd_next = hram_rd;
      RG_IE:   rd_next = ie_q;
      default: rd_next = 8'hFF;   // external RAM, unused I/O, overlay-off
    endcase
  end

  logic [7:0] rd_q;
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= 8'h00;
    else if (rd_en) rd_q <= rd_next;
  end
  assign rd_data = rd_q;

  logic       dbg_v_q;
  logic [7:0] dbg_b_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_v_q <= 1'b0;
      dbg_b_q <= 8'h00;
    end else begin
      dbg_v_q <= dbg_fire;
      if (dbg_fire) dbg_b_q <= ser_byte;
    end
  end
  assign dbg_valid = dbg_v_q;
  assign dbg_byte  = dbg_b_q;
endmodule

// File: rtl/membus_decoder_chk.sv
module membus_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] req_addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic        dbg_valid,
  input logic        boot_active,
  input logic        boot_clear
);
  p_boot_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |=> !boot_active);

  p_boot_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_clear |=> !boot_active);

  p_dbg_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == 16'hFF02 && wr_data == 8'h81) |=> dbg_valid);

  p_dbg_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && req_addr == 16'hFF02 && wr_data == 8'h81) |=> !dbg_valid);

  p_xram_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && req_addr[15:13] == 3'b101) |=> rd_data == 8'hFF);

  p_hole_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && req_addr >= 16'hFEA0 && req_addr < 16'hFF00) |=> rd_data == 8'h00);

  p_port0_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && req_addr == 16'hFF00) |=> rd_data == 8'hFF);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind membus_decoder membus_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .rd_en(rd_en),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .dbg_valid(dbg_valid), .boot_active(boot_active), .boot_clear(boot_clear)
);

// File: tb/membus_decoder_bench.sv
`timescale 1ns/1ps
module membus_decoder_bench;
  localparam int VAW = 10;
  localparam int WAW = 10;
  localparam int BLEN = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_en_i = 1'b1;
  logic [15:0] req_addr = 16'h0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h0;
  logic [7:0]  rd_data, rom_data, dbg_byte;
  logic [14:0] rom_addr;
  logic        dbg_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  membus_decoder #(.VRAM_AW(VAW), .WRAM_AW(WAW), .BOOT_LEN(BLEN)) u_membus_decoder (
    .clk(clk), .rst_n(rst_n), .boot_en_i(boot_en_i), .req_addr(req_addr),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rom_addr(rom_addr), .rom_data(rom_data), .dbg_valid(dbg_valid), .dbg_byte(dbg_byte)
  );

  function automatic logic [7:0] rom_fn(input logic [14:0] a);
    return ~a[7:0] ^ {1'b0, a[14:8]};
  endfunction
  assign rom_data = rom_fn(rom_addr);

  // Bench model of the map
  logic [7:0] m_vram [1<<VAW];
  logic [7:0] m_wram [1<<WAW];
  logic [7:0] m_oam  [160];
  logic [7:0] m_io   [76];
  logic [7:0] m_hram [127];
  logic [7:0] m_ie;
  bit         m_boot;

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    int ai = int'(a);
    if (ai < 'h8000) begin
      if (m_boot && ai < BLEN) return 8'(((ai % 256) ^ 'h5A) + (ai / 256));
      return rom_fn(a[14:0]);
    end
    if (ai < 'hA000) return m_vram[ai % (1<<VAW)];
    if (ai < 'hC000) return 8'hFF;
    if (ai < 'hE000) return m_wram[(ai - 'hC000) % (1<<WAW)];
    if (ai < 'hFE00) return m_wram[(ai - 'hE000) % (1<<WAW)];
    if (ai < 'hFEA0) return m_oam[ai - 'hFE00];
    if (ai < 'hFF00) return 8'h00;
    if (ai == 'hFF00) return 8'hFF;
    if (ai < 'hFF4C) return m_io[ai - 'hFF00];
    if (ai < 'hFF80) return 8'hFF;
    if (ai < 'hFFFF) return m_hram[ai - 'hFF80];
    return m_ie;
  endfunction

  task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
    int ai = int'(a);
    if (ai >= 'h8000 && ai < 'hA000) m_vram[ai % (1<<VAW)] = d;
    else if (ai >= 'hC000 && ai < 'hE000) m_wram[(ai - 'hC000) % (1<<WAW)] = d;
    else if (ai >= 'hE000 && ai < 'hFE00) m_wram[(ai - 'hE000) % (1<<WAW)] = d;
    else if (ai >= 'hFE00 && ai < 'hFEA0) m_oam[ai - 'hFE00] = d;
    else if (ai >= 'hFF00 && ai < 'hFF4C) m_io[ai - 'hFF00] = d;
    else if (ai == 'hFF50) m_boot = 0;
    else if (ai >= 'hFF80 && ai < 'hFFFF) m_hram[ai - 'hFF80] = d;
    else if (ai == 'hFFFF) m_ie = d;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    req_addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a);
    logic [7:0] exp, got;
    exp = exp_rd(a);
    bus_rd(a, got);
    chk($sformatf("%s addr %h", tag, a), {8'h0, got}, {8'h0, exp});
  endtask

  task automatic do_reset(input bit be);
    @(negedge clk);
    rst_n = 1'b0; boot_en_i = be; rd_en = 0; wr_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_boot = be; m_ie = 8'h00;
    for (int i = 0; i < 76; i++) m_io[i] = 8'hFF;
  endtask

  function automatic logic [15:0] rand_addr();
    int sel = int'($urandom % 9);
    case (sel)
      0: return 16'($urandom % 'h200);
      1: return 16'('h8000 + $urandom % (1<<VAW));
      2: return 16'('hA000 + $urandom % 'h2000);
      3: return 16'('hC000 + $urandom % (1<<WAW));
      4: return 16'('hE000 + $urandom % (1<<WAW));
      5: return 16'('hFE00 + $urandom % 'h100);
      6: return 16'('hFF00 + $urandom % 'h80);
      7: return 16'('hFF80 + $urandom % 'h80);
      default: return 16'($urandom % 'h10000);
    endcase
  endfunction

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    do_reset(1'b1);

    // reset state
    chk("R1 rom_addr follows address", {1'b0, rom_addr}, 16'h0000);
    rd_chk("R9 interrupt enable resets to 00", 16'hFFFF);
    rd_chk("R8 I/O byte resets to FF", 16'hFF10);
    rd_chk("R8 I/O last byte resets to FF", 16'hFF4B);

    // fill arrays so the model is fully known
    for (int i = 0; i < (1<<VAW); i++) bus_wr(16'('h8000 + i), 8'($urandom));
    for (int i = 0; i < (1<<WAW); i++) bus_wr(16'('hC000 + i), 8'($urandom));
    for (int i = 0; i < 160; i++) bus_wr(16'('hFE00 + i), 8'($urandom));
    for (int i = 0; i < 127; i++) bus_wr(16'('hFF80 + i), 8'($urandom));

    // overlay boundary
    rd_chk("R2 boot byte at 0", 16'h0000);
    rd_chk("R2 boot byte last", 16'(BLEN - 1));
    rd_chk("R1 ROM just past boot", 16'(BLEN));
    bus_wr(16'h0005, 8'h12);
    rd_chk("R1 ROM write ignored, overlay", 16'h0005);
    bus_wr(16'h4321, 8'h12);
    rd_chk("R1 ROM write ignored", 16'h4321);
    @(negedge clk); req_addr = 16'h6ABC; #1;
    chk("R1 rom_addr low 15 bits", {1'b0, rom_addr}, 16'h6ABC);

    // mirror both directions
    bus_wr(16'hC123, 8'hA7);
    rd_chk("R5 mirror read", 16'hE123);
    bus_wr(16'hE0F0, 8'h3C);
    rd_chk("R5 mirror write seen below", 16'hC0F0);
    rd_chk("R4 video RAM readback", 16'h8123);

    // holes
    bus_wr(16'hA010, 8'h55);
    rd_chk("R7 external RAM reads FF", 16'hA010);
    rd_chk("R7 video RAM untouched by external write", 16'h8010);
    bus_wr(16'hFEA5, 8'h77);
    rd_chk("R6 hole reads 00", 16'hFEA5);
    rd_chk("R6 sprite last byte", 16'hFE9F);
    bus_wr(16'hFF60, 8'h11);
    rd_chk("R7 unused I/O reads FF", 16'hFF60);
    bus_wr(16'hFF00, 8'h00);
    rd_chk("R8 port 0 always FF", 16'hFF00);
    bus_wr(16'hFF47, 8'h9C);
    rd_chk("R8 I/O readback", 16'hFF47);
    bus_wr(16'hFFFE, 8'h6D);
    rd_chk("R9 high RAM top", 16'hFFFE);
    bus_wr(16'hFFFF, 8'h1F);
    rd_chk("R9 interrupt enable write", 16'hFFFF);

    // debug strobe
    bus_wr(16'hFF01, 8'h4B);
    bus_wr(16'hFF02, 8'h81);
    chk("R10 strobe high", {15'h0, dbg_valid}, 16'h1);
    chk("R10 strobe byte", {8'h0, dbg_byte}, 16'h004B);
    @(posedge clk); #1;
    chk("R10 strobe one cycle", {15'h0, dbg_valid}, 16'h0);
    rd_chk("R10 start code stored", 16'hFF02);
    bus_wr(16'hFF02, 8'h80);
    chk("R10 other value no strobe", {15'h0, dbg_valid}, 16'h0);

    // read hold and read-during-write
    rd_chk("R11 setup read", 16'h8200);
    @(negedge clk); req_addr = 16'hFFFF;
    @(posedge clk); #1;
    chk("R11 hold without read", {8'h0, rd_data}, {8'h0, exp_rd(16'h8200)});
    @(negedge clk);
    v = exp_rd(16'h8200);
    req_addr = 16'h8200; rd_en = 1; wr_en = 1; wr_data = ~v;
    @(posedge clk); #1;
    rd_en = 0; wr_en = 0;
    chk("R11 read during write gives old", {8'h0, rd_data}, {8'h0, v});
    model_wr(16'h8200, ~v);
    rd_chk("R4 new value after write", 16'h8200);

    // overlay clear
    bus_wr(16'hFF50, 8'h00);
    rd_chk("R3 overlay cleared", 16'h0010);
    bus_wr(16'hFF50, 8'h01);
    rd_chk("R3 overlay stays cleared", 16'h0000);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a;
      a = rand_addr();
      if ($urandom % 2 == 0) bus_wr(a, 8'($urandom));
      else rd_chk("R4 random read", a);
    end

    // reset with overlay off
    do_reset(1'b0);
    rd_chk("R3 reset with enable low", 16'h0020);
    rd_chk("R8 I/O back to FF after reset", 16'hFF47);
    rd_chk("R9 IE back to 00 after reset", 16'hFFFF);
    do_reset(1'b1);
    rd_chk("R3 reset with enable high", 16'h0020);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule